// File: doc/BRIEF.md
# Coherent Address-Channel Request Generator

This block sits between a core's memory pipeline and a coherent AXI-style master port. It turns one internal request into the address-phase fields of either the read or the write address channel. Each request carries an operation, a memory type, a shareability class, a cache-hit hint, a byte address, an access size and a beat count. From these the block picks the channel, the burst shape, the coherent transaction code and the domain. It also drives the exclusive-access lock bit.

Requests arrive on a valid/ready input. Each output channel has a single holding register with its own valid/ready handshake, so each channel carries at most one outstanding request. If a request breaks the size, beat-count, alignment or line rules, or uses a reserved code, it is accepted but not issued. Instead an error pulse is raised for one cycle. Cache lines are 64 bytes and full-width beats are 128 bits.

Top module: `coh_req_gen`

## Requirements
- R1: Every issued burst is INCR (code 01) or WRAP (code 10). The FIXED code 00 never appears on either channel.
- R2: A linefill to write-back memory (reqOp=4, reqMem=2) issues a read WRAP burst with length 3 and size 4. The same applies to a plain load (reqOp=0) or exclusive load (reqOp=2) to shared write-back memory. The address is the request address with its low 4 bits cleared, so the critical 16-byte chunk is fetched first.
- R3: An eviction (reqOp=5) of write-back memory issues a write INCR burst with length 3 and size 4 at the 64-byte-aligned address. The snoop code is WriteBack (011) when shared and WriteNoSnoop (000) when non-shared. An eviction of device or non-cacheable memory is an error.
- R4: A plain access on the NoSnoop path (reqOp 0..3) issues INCR with length = beats-1 and size = reqSize, where reqSize is log2 of bytes per beat. The beat count must be 1, 2 or 4, reqSize must be at most 4, and any multi-beat access must use size 4. Otherwise the request is an error.
- R5: A plain access must be aligned to its size and must not run past the end of its 64-byte line (line offset + beats*bytes <= 64). Otherwise it is an error.
- R6: A single-beat non-exclusive load of non-cacheable memory (reqMem=1) needs a size of at least 2, i.e. 32 bits. Device reads and exclusive reads may use any size from 0 to 4.
- R7: Device memory (reqMem=0) and non-cacheable memory (reqMem=1) use snoop code 0 and domain 11 (system). Non-shared write-back memory (reqShare=0) uses snoop code 0 and domain 00 (non-shareable). Loads go to the read channel and stores to the write channel.
- R8: An exclusive load (reqOp=2) or exclusive store (reqOp=3) on the NoSnoop path drives the lock bit of its channel high. It must be single-beat, otherwise it is an error.
- R9: For shared write-back memory, the domain equals reqShare (01 inner, 10 outer). A load or linefill issues ReadShared (0001). A store (reqOp=1) with reqHit=0 issues ReadUnique (0111) as a WRAP fill. A store with reqHit=1 issues CleanUnique (1011) on the read channel as an INCR burst with length 0 and size 4 at the line-aligned address.
- R10: For shared write-back memory, an exclusive load issues ReadShared with lock high as a WRAP fill. An exclusive store issues CleanUnique with lock high, shaped as in R9.
- R11: A request that is in error is accepted with reqReady high and issued on no channel. reqErr is high for exactly the one cycle after the accepting edge. Reserved codes are errors: reqOp 6-7, reqMem 3 and reqShare 3.
- R12: While a channel holds a request that its ready has not taken, that channel's valid and fields stay unchanged. reqReady stays low for a new request that targets that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqOp | input | 3 | 0 load, 1 store, 2 excl load, 3 excl store, 4 linefill, 5 eviction |
| reqMem | input | 2 | 0 device, 1 normal non-cacheable, 2 write-back |
| reqShare | input | 2 | 0 non-shared, 1 inner, 2 outer |
| reqHit | input | 1 | Store hits a line held in a non-unique state |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 3 | log2 bytes per beat |
| reqBeats | input | 3 | Beat count |
| reqErr | output | 1 | One-cycle pulse for a rejected request |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arAddr | output | ADDR_W | Read address |
| arLen | output | 8 | Beats minus one |
| arSize | output | 3 | Beat size code |
| arBurst | output | 2 | Burst type |
| arLock | output | 1 | Exclusive access |
| arSnoop | output | 4 | Read transaction code |
| arDomain | output | 2 | Shareability domain |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | output | ADDR_W | Write address |
| awLen | output | 8 | Beats minus one |
| awSize | output | 3 | Beat size code |
| awBurst | output | 2 | Burst type |
| awLock | output | 1 | Exclusive access |
| awSnoop | output | 3 | Write transaction code |
| awDomain | output | 2 | Shareability domain |

## Verification
The embedded properties check the burst-shape rules on every cycle a channel is valid: no FIXED code, WRAP only as 4x128-bit, and no INCR that crosses a line. They also check that a held channel keeps its fields and valid until ready, that an error pulse only follows an accepting edge, and that a locked write is always NoSnoop. The mapping from operation, memory type, shareability and hit state to snoop code, domain, lock and start address can only be shown by the bench's scenarios. The same holds for each rejection rule and for back-pressure on a stalled channel.

// File: rtl/creq_pkg.sv
package creq_pkg;
  localparam int LINE_LG = 6;
  localparam int BEAT_LG = 4;
  localparam int LEN_W   = 8;

  localparam logic [2:0]  SIZE_BEAT  = 3'(BEAT_LG);
  localparam logic [11:0] LINE_BYTES = 12'(1 << LINE_LG);
  localparam logic [7:0]  FILL_LEN   = 8'd3;

  localparam logic [2:0] OP_LOAD   = 3'd0;
  localparam logic [2:0] OP_STORE  = 3'd1;
  localparam logic [2:0] OP_XLOAD  = 3'd2;
  localparam logic [2:0] OP_XSTORE = 3'd3;
  localparam logic [2:0] OP_FILL   = 3'd4;
  localparam logic [2:0] OP_EVICT  = 3'd5;

  localparam logic [1:0] MEM_DEV  = 2'd0;
  localparam logic [1:0] MEM_NC   = 2'd1;
  localparam logic [1:0] MEM_WB   = 2'd2;
  localparam logic [1:0] MEM_RSVD = 2'd3;

  localparam logic [1:0] SH_NONE = 2'd0;
  localparam logic [1:0] SH_RSVD = 2'd3;

  localparam logic [1:0] DOM_NONSH = 2'b00;
  localparam logic [1:0] DOM_SYS   = 2'b11;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] BURST_WRAP = 2'b10;

  localparam logic [3:0] SN_NOSNOOP  = 4'b0000;
  localparam logic [3:0] SN_RDSHARED = 4'b0001;
  localparam logic [3:0] SN_RDUNIQUE = 4'b0111;
  localparam logic [3:0] SN_CLUNIQUE = 4'b1011;
  localparam logic [3:0] SN_WRBACK   = 4'b0011;

  // shape of the address phase
  localparam logic [1:0] K_PLAIN = 2'd0;  // as requested
  localparam logic [1:0] K_FILL  = 2'd1;  // wrap 4x128, critical chunk
  localparam logic [1:0] K_LINE  = 2'd2;  // incr 4x128, line aligned
  localparam logic [1:0] K_ADDR  = 2'd3;  // one beat, line aligned

  typedef struct packed {
    logic loadAr;
    logic loadAw;
  } strobe_t;

  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] snoop;
    logic [1:0] domain;
    logic       lock;
  } fields_t;
endpackage

// File: rtl/creq_ctrl.sv
module creq_ctrl
  import creq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [2:0]           reqOp,
  input  logic [1:0]           reqMem,
  input  logic [1:0]           reqShare,
  input  logic                 reqHit,
  input  logic [LINE_LG-1:0]   reqOff,
  input  logic [2:0]           reqSize,
  input  logic [2:0]           reqBeats,
  output logic                 reqErr,
  input  logic                 arReady,
  input  logic                 awReady,
  output logic                 arValid,
  output logic                 awValid,
  output strobe_t              strb,
  output fields_t              fld
);
  logic sharedWb, toAw, plain, bad, plainBad;
  logic arFree, awFree, take;

  // legality of an as-requested access
  logic excl, multi, sizeBad, beatsBad, wideBad, exclBad, narrowBad, alignBad, crossBad;
  logic [LINE_LG-1:0] byteMask;
  logic [11:0]        span;

  always_comb begin
    excl      = (reqOp == OP_XLOAD) || (reqOp == OP_XSTORE);
    multi     = (reqBeats != 3'd1);
    sizeBad   = (reqSize > SIZE_BEAT);
    beatsBad  = !((reqBeats == 3'd1) || (reqBeats == 3'd2) || (reqBeats == 3'd4));
    wideBad   = multi && (reqSize != SIZE_BEAT);
    exclBad   = excl && multi;
    narrowBad = (reqMem == MEM_NC) && (reqOp == OP_LOAD) && (reqSize < 3'd2);
    byteMask  = LINE_LG'((8'd1 << reqSize) - 8'd1);
    alignBad  = (reqOff & byteMask) != '0;
    span      = 12'(reqOff) + (12'(reqBeats) << reqSize);
    crossBad  = span > LINE_BYTES;
    plainBad  = sizeBad | beatsBad | wideBad | exclBad | narrowBad | alignBad | crossBad;
  end

  // transaction selection
  always_comb begin
    fld      = '0;
    toAw     = 1'b0;
    plain    = 1'b0;
    bad      = 1'b0;
    sharedWb = (reqMem == MEM_WB) && (reqShare != SH_NONE);
    if (reqOp > OP_EVICT || reqMem == MEM_RSVD || reqShare == SH_RSVD) begin
      bad = 1'b1;
    end else if (sharedWb) begin
      fld.domain = reqShare;
      case (reqOp)
        OP_LOAD, OP_FILL: begin
          fld.kind  = K_FILL;
          fld.snoop = SN_RDSHARED;
        end
        OP_XLOAD: begin
          fld.kind  = K_FILL;
          fld.snoop = SN_RDSHARED;
          fld.lock  = 1'b1;
        end
        OP_STORE: begin
          fld.kind  = reqHit ? K_ADDR : K_FILL;
          fld.snoop = reqHit ? SN_CLUNIQUE : SN_RDUNIQUE;
        end
        OP_XSTORE: begin
          fld.kind  = K_ADDR;
          fld.snoop = SN_CLUNIQUE;
          fld.lock  = 1'b1;
        end
        default: begin
          fld.kind  = K_LINE;
          fld.snoop = SN_WRBACK;
          toAw      = 1'b1;
        end
      endcase
    end else begin
      fld.domain = (reqMem == MEM_WB) ? DOM_NONSH : DOM_SYS;
      fld.snoop  = SN_NOSNOOP;
      case (reqOp)
        OP_LOAD, OP_XLOAD: begin
          fld.kind = K_PLAIN;
          fld.lock = (reqOp == OP_XLOAD);
          plain    = 1'b1;
        end
        OP_STORE, OP_XSTORE: begin
          fld.kind = K_PLAIN;
          fld.lock = (reqOp == OP_XSTORE);
          plain    = 1'b1;
          toAw     = 1'b1;
        end
        OP_FILL: begin
          fld.kind = K_FILL;
          bad      = (reqMem != MEM_WB);
        end
        default: begin
          fld.kind = K_LINE;
          toAw     = 1'b1;
          bad      = (reqMem != MEM_WB);
        end
      endcase
    end
    if (plain) bad = bad | plainBad;
  end

  // handshake
  always_comb begin
    arFree      = !arValid || arReady;
    awFree      = !awValid || awReady;
    reqReady    = bad ? 1'b1 : (toAw ? awFree : arFree);
    take        = reqValid && reqReady;
    strb.loadAr = take && !bad && !toAw;
    strb.loadAw = take && !bad && toAw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arValid <= 1'b0;
      awValid <= 1'b0;
      reqErr  <= 1'b0;
    end else begin
      if (strb.loadAr)  arValid <= 1'b1;
      else if (arReady) arValid <= 1'b0;
      if (strb.loadAw)  awValid <= 1'b1;
      else if (awReady) awValid <= 1'b0;
      reqErr <= take && bad;
    end
  end

  // R11: an error pulse only follows an accepting edge
  a_r11_err_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $past(reqValid && reqReady));
  // R12: a held read request stays posted until taken
  a_r12_ar_hold: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid);
  a_r12_aw_hold: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid);
endmodule

// File: rtl/creq_dpath.sv
module creq_dpath
  import creq_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  fields_t           fld,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [2:0]        reqBeats,
  input  logic              arValid,
  input  logic              arReady,
  input  logic              awValid,
  input  logic              awReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [LEN_W-1:0]  arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic              arLock,
  output logic [3:0]        arSnoop,
  output logic [1:0]        arDomain,
  output logic [ADDR_W-1:0] awAddr,
  output logic [LEN_W-1:0]  awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              awLock,
  output logic [2:0]        awSnoop,
  output logic [1:0]        awDomain
);
  logic [ADDR_W-1:0] nxtAddr;
  logic [LEN_W-1:0]  nxtLen;
  logic [2:0]        nxtSize;
  logic [1:0]        nxtBurst;

  always_comb begin
    case (fld.kind)
      K_FILL: begin
        nxtAddr  = {reqAddr[ADDR_W-1:BEAT_LG], BEAT_LG'(0)};
        nxtLen   = FILL_LEN;
        nxtSize  = SIZE_BEAT;
        nxtBurst = BURST_WRAP;
      end
      K_LINE: begin
        nxtAddr  = {reqAddr[ADDR_W-1:LINE_LG], LINE_LG'(0)};
        nxtLen   = FILL_LEN;
        nxtSize  = SIZE_BEAT;
        nxtBurst = BURST_INCR;
      end
      K_ADDR: begin
        nxtAddr  = {reqAddr[ADDR_W-1:LINE_LG], LINE_LG'(0)};
        nxtLen   = '0;
        nxtSize  = SIZE_BEAT;
        nxtBurst = BURST_INCR;
      end
      default: begin
        nxtAddr  = reqAddr;
        nxtLen   = LEN_W'(reqBeats - 3'd1);
        nxtSize  = reqSize;
        nxtBurst = BURST_INCR;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arAddr <= '0; arLen <= '0; arSize <= '0; arBurst <= BURST_INCR;
      arLock <= 1'b0; arSnoop <= '0; arDomain <= '0;
    end else if (strb.loadAr) begin
      arAddr <= nxtAddr; arLen <= nxtLen; arSize <= nxtSize; arBurst <= nxtBurst;
      arLock <= fld.lock; arSnoop <= fld.snoop; arDomain <= fld.domain;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awAddr <= '0; awLen <= '0; awSize <= '0; awBurst <= BURST_INCR;
      awLock <= 1'b0; awSnoop <= '0; awDomain <= '0;
    end else if (strb.loadAw) begin
      awAddr <= nxtAddr; awLen <= nxtLen; awSize <= nxtSize; awBurst <= nxtBurst;
      awLock <= fld.lock; awSnoop <= fld.snoop[2:0]; awDomain <= fld.domain;
    end
  end

  // R1: never a FIXED burst
  a_r1_ar_no_fixed: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> arBurst != 2'b00);
  a_r1_aw_no_fixed: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> awBurst != 2'b00);
  // R2: a wrap is always a full 4x128-bit line
  a_r2_wrap_shape: assert property (@(posedge clk) disable iff (!rstN)
    arValid && arBurst == BURST_WRAP |-> arLen == FILL_LEN && arSize == SIZE_BEAT);
  // R5: no increment burst crosses a line
  a_r5_ar_no_cross: assert property (@(posedge clk) disable iff (!rstN)
    arValid && arBurst == BURST_INCR |->
      (16'(arAddr[LINE_LG-1:0]) + ((16'(arLen) + 16'd1) << arSize)) <= 16'(LINE_BYTES));
  a_r5_aw_no_cross: assert property (@(posedge clk) disable iff (!rstN)
    awValid && awBurst == BURST_INCR |->
      (16'(awAddr[LINE_LG-1:0]) + ((16'(awLen) + 16'd1) << awSize)) <= 16'(LINE_BYTES));
  // R8: a locked write is always NoSnoop
  a_r8_aw_lock_nosnoop: assert property (@(posedge clk) disable iff (!rstN)
    awValid && awLock |-> awSnoop == 3'b000);
  // R12: held fields stay put
  a_r12_ar_stable: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> $stable(arAddr) && $stable(arLen) && $stable(arSnoop)
                            && $stable(arLock) && $stable(arDomain));
  a_r12_aw_stable: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> $stable(awAddr) && $stable(awLen) && $stable(awSnoop)
                            && $stable(awLock) && $stable(awDomain));
endmodule

// File: rtl/coh_req_gen.sv
module coh_req_gen
  import creq_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [1:0]        reqMem,
  input  logic [1:0]        reqShare,
  input  logic              reqHit,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [2:0]        reqBeats,
  output logic              reqErr,
  output logic              arValid,
  input  logic              arReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic              arLock,
  output logic [3:0]        arSnoop,
  output logic [1:0]        arDomain,
  output logic              awValid,
  input  logic              awReady,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              awLock,
  output logic [2:0]        awSnoop,
  output logic [1:0]        awDomain
);
  strobe_t strb;
  fields_t fld;

  creq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqMem(reqMem), .reqShare(reqShare), .reqHit(reqHit),
    .reqOff(reqAddr[LINE_LG-1:0]), .reqSize(reqSize), .reqBeats(reqBeats),
    .reqErr(reqErr),
    .arReady(arReady), .awReady(awReady),
    .arValid(arValid), .awValid(awValid),
    .strb(strb), .fld(fld)
  );

  creq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .fld(fld),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqBeats(reqBeats),
    .arValid(arValid), .arReady(arReady),
    .awValid(awValid), .awReady(awReady),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arLock(arLock), .arSnoop(arSnoop), .arDomain(arDomain),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awLock(awLock), .awSnoop(awSnoop), .awDomain(awDomain)
  );
endmodule

// File: tb/coh_req_gen_test.sv
module coh_req_gen_test;
  localparam int AW = 40;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [7:0]    len;
    logic [2:0]    size;
    logic [1:0]    burst;
    logic          lock;
    logic [3:0]    snoop;
    logic [1:0]    dom;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqHit = 0, arReady = 1, awReady = 1;
  logic [2:0] reqOp = 0, reqSize = 0, reqBeats = 1;
  logic [1:0] reqMem = 0, reqShare = 0;
  logic [AW-1:0] reqAddr = 0;
  logic reqReady, reqErr, arValid, awValid, arLock, awLock;
  logic [AW-1:0] arAddr, awAddr;
  logic [7:0] arLen, awLen;
  logic [2:0] arSize, awSize, awSnoop;
  logic [1:0] arBurst, awBurst, arDomain, awDomain;
  logic [3:0] arSnoop;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t arQ[$], awQ[$];
  string arTagQ[$], awTagQ[$], errTagQ[$];

  always #2 clk = ~clk;   // 250 MHz

  coh_req_gen #(.ADDR_W(AW)) uut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic present(input logic [2:0] op, input logic [1:0] mem, input logic [1:0] sh,
                         input logic hit, input logic [AW-1:0] a, input logic [2:0] sz,
                         input logic [2:0] bt);
    @(negedge clk);
    reqOp = op; reqMem = mem; reqShare = sh; reqHit = hit;
    reqAddr = a; reqSize = sz; reqBeats = bt; reqValid = 1;
    forever begin
      #1;
      if (reqReady) begin
        @(negedge clk);
        reqValid = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  // driver: chan 0 read, 1 write
  task automatic sendOk(input string tag, input int chan,
                        input logic [2:0] op, input logic [1:0] mem, input logic [1:0] sh,
                        input logic hit, input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [2:0] bt, input exp_t e);
    if (chan == 0) begin arQ.push_back(e); arTagQ.push_back(tag); end
    else begin awQ.push_back(e); awTagQ.push_back(tag); end
    present(op, mem, sh, hit, a, sz, bt);
  endtask

  task automatic sendErr(input string tag,
                         input logic [2:0] op, input logic [1:0] mem, input logic [1:0] sh,
                         input logic hit, input logic [AW-1:0] a, input logic [2:0] sz,
                         input logic [2:0] bt);
    errTagQ.push_back(tag);
    present(op, mem, sh, hit, a, sz, bt);
  endtask

  function automatic exp_t mk(input logic [AW-1:0] a, input logic [7:0] l, input logic [2:0] s,
                              input logic [1:0] b, input logic k, input logic [3:0] sn,
                              input logic [1:0] d);
    exp_t e;
    e.addr = a; e.len = l; e.size = s; e.burst = b; e.lock = k; e.snoop = sn; e.dom = d;
    return e;
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (arValid && arReady) begin
          exp_t act;
          act = mk(arAddr, arLen, arSize, arBurst, arLock, arSnoop, arDomain);
          if (arQ.size() == 0) chk("R11 unexpected read issue", 128'(act), 128'(0));
          else chk(arTagQ.pop_front(), 128'(act), 128'(arQ.pop_front()));
        end
        if (awValid && awReady) begin
          exp_t act;
          act = mk(awAddr, awLen, awSize, awBurst, awLock, {1'b0, awSnoop}, awDomain);
          if (awQ.size() == 0) chk("R11 unexpected write issue", 128'(act), 128'(0));
          else chk(awTagQ.pop_front(), 128'(act), 128'(awQ.pop_front()));
        end
        if (reqErr) begin
          if (errTagQ.size() == 0) chk("R11 unexpected error pulse", 128'(1), 128'(0));
          else chk(errTagQ.pop_front(), 128'(1), 128'(1));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("reset arValid", 128'(arValid), 128'(0));
    chk("reset awValid", 128'(awValid), 128'(0));
    chk("reset reqErr", 128'(reqErr), 128'(0));
    chk("reset reqReady", 128'(reqReady), 128'(1));

    // fills and coherent ops (R1 checked by every burst field)
    sendOk("R2 R9 linefill inner wb", 0, 3'd4, 2'd2, 2'd1, 0, 40'h1234, 3'd4, 3'd4,
           mk(40'h1230, 8'd3, 3'd4, 2'b10, 0, 4'b0001, 2'b01));
    sendOk("R2 R7 linefill nonshared wb", 0, 3'd4, 2'd2, 2'd0, 0, 40'h2078, 3'd4, 3'd4,
           mk(40'h2070, 8'd3, 3'd4, 2'b10, 0, 4'b0000, 2'b00));
    sendOk("R2 R9 load outer wb", 0, 3'd0, 2'd2, 2'd2, 0, 40'h2504, 3'd2, 3'd1,
           mk(40'h2500, 8'd3, 3'd4, 2'b10, 0, 4'b0001, 2'b10));
    sendOk("R9 store miss outer", 0, 3'd1, 2'd2, 2'd2, 0, 40'h3044, 3'd2, 3'd1,
           mk(40'h3040, 8'd3, 3'd4, 2'b10, 0, 4'b0111, 2'b10));
    sendOk("R9 store hit inner", 0, 3'd1, 2'd2, 2'd1, 1, 40'h30A4, 3'd2, 3'd1,
           mk(40'h3080, 8'd0, 3'd4, 2'b01, 0, 4'b1011, 2'b01));
    sendOk("R3 evict shared", 1, 3'd5, 2'd2, 2'd1, 0, 40'h4050, 3'd4, 3'd4,
           mk(40'h4040, 8'd3, 3'd4, 2'b01, 0, 4'b0011, 2'b01));
    sendOk("R3 evict nonshared", 1, 3'd5, 2'd2, 2'd0, 0, 40'h4090, 3'd4, 3'd4,
           mk(40'h4080, 8'd3, 3'd4, 2'b01, 0, 4'b0000, 2'b00));
    sendErr("R3 evict device", 3'd5, 2'd0, 2'd0, 0, 40'h4100, 3'd4, 3'd4);
    sendErr("R2 linefill noncacheable", 3'd4, 2'd1, 2'd0, 0, 40'h4200, 3'd4, 3'd4);

    // plain NoSnoop accesses
    sendOk("R4 R7 nc load 2 beats", 0, 3'd0, 2'd1, 2'd0, 0, 40'h5020, 3'd4, 3'd2,
           mk(40'h5020, 8'd1, 3'd4, 2'b01, 0, 4'b0000, 2'b11));
    sendOk("R4 R7 device store 4 beats", 1, 3'd1, 2'd0, 2'd0, 0, 40'h5000, 3'd4, 3'd4,
           mk(40'h5000, 8'd3, 3'd4, 2'b01, 0, 4'b0000, 2'b11));
    sendOk("R7 nonshared wb store", 1, 3'd1, 2'd2, 2'd0, 0, 40'h8010, 3'd4, 3'd1,
           mk(40'h8010, 8'd0, 3'd4, 2'b01, 0, 4'b0000, 2'b00));
    sendErr("R4 narrow multi-beat", 3'd0, 2'd0, 2'd0, 0, 40'h5040, 3'd2, 3'd2);
    sendErr("R4 three beats", 3'd1, 2'd1, 2'd0, 0, 40'h5080, 3'd4, 3'd3);
    sendErr("R4 size over 128 bits", 3'd0, 2'd0, 2'd0, 0, 40'h5100, 3'd5, 3'd1);
    sendErr("R5 line crossing", 3'd1, 2'd1, 2'd0, 0, 40'h5010, 3'd4, 3'd4);
    sendErr("R5 misaligned", 3'd1, 2'd1, 2'd0, 0, 40'h5002, 3'd2, 3'd1);
    sendErr("R6 nc 16-bit load", 3'd0, 2'd1, 2'd0, 0, 40'h6000, 3'd1, 3'd1);
    sendOk("R6 device byte load", 0, 3'd0, 2'd0, 2'd0, 0, 40'h6001, 3'd0, 3'd1,
           mk(40'h6001, 8'd0, 3'd0, 2'b01, 0, 4'b0000, 2'b11));
    sendOk("R6 nc 32-bit load", 0, 3'd0, 2'd1, 2'd0, 0, 40'h6004, 3'd2, 3'd1,
           mk(40'h6004, 8'd0, 3'd2, 2'b01, 0, 4'b0000, 2'b11));

    // exclusives
    sendOk("R8 excl load device", 0, 3'd2, 2'd0, 2'd0, 0, 40'h6008, 3'd3, 3'd1,
           mk(40'h6008, 8'd0, 3'd3, 2'b01, 1, 4'b0000, 2'b11));
    sendOk("R8 excl store nc byte", 1, 3'd3, 2'd1, 2'd0, 0, 40'h6003, 3'd0, 3'd1,
           mk(40'h6003, 8'd0, 3'd0, 2'b01, 1, 4'b0000, 2'b11));
    sendErr("R8 excl multi-beat", 3'd2, 2'd1, 2'd0, 0, 40'h6040, 3'd4, 3'd2);
    sendOk("R10 excl load inner wb", 0, 3'd2, 2'd2, 2'd1, 0, 40'h7018, 3'd3, 3'd1,
           mk(40'h7010, 8'd3, 3'd4, 2'b10, 1, 4'b0001, 2'b01));
    sendOk("R10 excl store outer wb", 0, 3'd3, 2'd2, 2'd2, 0, 40'h7020, 3'd3, 3'd1,
           mk(40'h7000, 8'd0, 3'd4, 2'b01, 1, 4'b1011, 2'b10));

    // reserved codes, back to back
    sendErr("R11 op 6", 3'd6, 2'd0, 2'd0, 0, 40'h7100, 3'd2, 3'd1);
    sendErr("R11 mem 3", 3'd0, 2'd3, 2'd0, 0, 40'h7100, 3'd2, 3'd1);
    sendErr("R11 share 3", 3'd4, 2'd2, 2'd3, 0, 40'h7100, 3'd4, 3'd4);
    @(negedge clk); #1;
    chk("R11 error pulse ends", 128'(reqErr), 128'(0));
    chk("R11 nothing issued", 128'({arValid, awValid}), 128'(0));

    // back-pressure on the read channel
    arReady = 0;
    sendOk("R12 stalled fill first", 0, 3'd4, 2'd2, 2'd1, 0, 40'h9008, 3'd4, 3'd4,
           mk(40'h9000, 8'd3, 3'd4, 2'b10, 0, 4'b0001, 2'b01));
    fork
      sendOk("R12 stalled fill second", 0, 3'd4, 2'd2, 2'd2, 0, 40'h9100, 3'd4, 3'd4,
             mk(40'h9100, 8'd3, 3'd4, 2'b10, 0, 4'b0001, 2'b10));
      begin
        repeat (3) @(negedge clk);
        #1;
        chk("R12 ready low while held", 128'(reqReady), 128'(0));
        chk("R12 valid held", 128'(arValid), 128'(1));
        chk("R12 address held", 128'(arAddr), 128'(40'h9000));
        chk("R12 domain held", 128'(arDomain), 128'(2'b01));
        @(negedge clk);
        arReady = 1;
      end
    join

    repeat (6) @(negedge clk);
    #1;
    chk("R11 all expected items seen", 128'(arQ.size() + awQ.size() + errTagQ.size()), 128'(0));
    finishRun();
  end
endmodule